// File: doc/BRIEF.md
# Timer Compare Channel with Switching State Bit

This block is one compare channel that sits beside an up-counting timer. Software puts a new compare value into a shadow register through a small valid/ready write port. The value becomes active only when the timer logic pulses a shadow-transfer strobe, so the new compare setting and any related settings can all take effect on the same cycle. An equality comparator checks the incoming counter value against the active compare register. On each timer tick where they are equal, the block raises a single-cycle match event for the interrupt logic.

The channel also holds a state bit for the output stage. While the timer runs, hardware updates this bit on the tick that follows an event:

- It is set after a compare match, which is the moment the counter steps past the compare value.
- It is set after a zero match that lands together with a compare match.
- It is cleared after a zero match that has no compare match with it.

When the timer is stopped, hardware leaves the bit alone. Software may force the bit high or low at any time, and a software strobe wins over any hardware update in the same cycle.

Top module: `tmr_cmp_chan`

## Requirements
- R1: A shadow write is taken on a clock edge where `wr_valid_i` and `wr_ready_o` are both 1. `wr_ready_o` is 0 in exactly the cycles where `xfer_i` is 1, and 1 otherwise. A writer that sees ready low keeps valid and data steady, and its write is then taken on a later cycle.
- R2: The active compare register takes the shadow value only on an edge where `xfer_i` is 1. The value copied is the one the shadow held before that edge. A shadow write alone does not change which counter value matches.
- R3: `match_o` is 1 for exactly the one cycle after an edge where `tick_i` was 1 and `cnt_i` equalled the active compare value. A counter held at the compare value with `tick_i` at 0 raises no further pulse.
- R4: `match_o` follows R3 whatever the value of `state_o`, and whether the timer is running or stopped.
- R5: With `run_i` at 1, a tick where the counter equals the compare value sets `state_o` to 1 on the next tick. The next tick must also have `run_i` at 1.
- R6: With `run_i` at 1, a tick where `zero_i` and a compare match coincide sets `state_o` to 1 on the next running tick.
- R7: With `run_i` at 1, a tick where `zero_i` is 1 and there is no compare match clears `state_o` to 0 on the next running tick.
- R8: Hardware does not change `state_o` in these cases:
  - a tick where `run_i` is 0;
  - an event seen while `run_i` is 0, which is never applied later.
- R9: `sw_set_i` alone forces `state_o` to 1 on the next edge, and `sw_clr_i` alone forces it to 0. Either strobe overrides a hardware update in the same cycle.
- R10: When `sw_set_i` and `sw_clr_i` are both 1, `state_o` keeps its value, and any hardware update due in that cycle is dropped.
- R11: After reset:
  - the compare and shadow registers are 0;
  - `state_o` is 0;
  - `match_o` is 0;
  - `wr_ready_o` is 1 while `xfer_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable, one cycle per count |
| cnt_i | input | CNT_W | Current counter value |
| run_i | input | 1 | Timer running flag |
| zero_i | input | 1 | Counter zero-match flag, qualified by tick_i |
| xfer_i | input | 1 | Shadow-to-active transfer strobe |
| wr_valid_i | input | 1 | Shadow write request |
| wr_ready_o | output | 1 | Shadow write can be taken this cycle |
| wr_data_i | input | CNT_W | Shadow write value |
| sw_set_i | input | 1 | Software force of the state bit to 1 |
| sw_clr_i | input | 1 | Software force of the state bit to 0 |
| match_o | output | 1 | Registered compare-match event pulse |
| state_o | output | 1 | Channel state bit |

## Verification
The hardest case to reach from the ports is a hardware update that meets another influence in the same cycle. Three such collisions matter: a pending set or clear that meets a software strobe on the applying tick, an event recorded while running that meets a stopped timer when it is due, and a shadow write that meets a transfer strobe. The stimulus loads a compare value through the shadow path and then steps the counter one tick at a time, with idle cycles in between. It places the strobe, the `run_i` drop or the write exactly on the tick after a match or zero match. A bench model predicts the state bit and the match pulse for every cycle.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  // Hardware action requested for the state bit on a running tick.
  typedef enum logic [1:0] {
    HW_HOLD = 2'd0,
    HW_SET  = 2'd1,
    HW_CLR  = 2'd2
  } hw_act_e;

  // Software command decoded from the set/clear strobes.
  typedef enum logic [1:0] {
    SW_NONE  = 2'd0,
    SW_FORCE1 = 2'd1,
    SW_FORCE0 = 2'd2,
    SW_BOTH  = 2'd3
  } sw_cmd_e;

  function automatic sw_cmd_e sw_decode(input logic set_s, input logic clr_s);
    sw_cmd_e cmd;
    unique case ({set_s, clr_s})
      2'b10:   cmd = SW_FORCE1;
      2'b01:   cmd = SW_FORCE0;
      2'b11:   cmd = SW_BOTH;
      default: cmd = SW_NONE;
    endcase
    return cmd;
  endfunction

endpackage

// File: rtl/tcmp_regs.sv
// Double-buffered compare value: shadow loaded by the write port,
// active register loaded from the shadow on the transfer strobe.
module tcmp_regs #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] shadow_o,
  output logic [CNT_W-1:0] active_o
);

  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] active_q;
  logic             wr_take;

  // A write is held off during a transfer so the copied value is well defined.
  assign wr_ready_o = ~xfer_i;
  assign wr_take    = wr_valid_i & wr_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (wr_take) begin
      shadow_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
    end else if (xfer_i) begin
      active_q <= shadow_q;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

endmodule

// File: rtl/tcmp_match.sv
// Equality comparator and registered, tick-qualified event pulse.
module tcmp_match #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] active_i,
  output logic             eq_o,
  output logic             match_o
);

  logic match_q;

  assign eq_o = (cnt_i == active_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
    end else begin
      match_q <= tick_i & eq_o;
    end
  end

  assign match_o = match_q;

endmodule

// File: rtl/tcmp_state.sv
// State bit switching rules: events seen on one running tick are applied
// on the next running tick; software strobes override.
module tcmp_state
  import tcmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic eq_i,
  input  logic zero_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic state_o
);

  logic    cm_seen_q;
  logic    zm_seen_q;
  logic    state_q;
  logic    state_d;
  hw_act_e hw_act;
  sw_cmd_e sw_cmd;

  // Events are recorded only while the timer runs.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cm_seen_q <= 1'b0;
      zm_seen_q <= 1'b0;
    end else if (tick_i) begin
      cm_seen_q <= run_i & eq_i;
      zm_seen_q <= run_i & zero_i;
    end
  end

  always_comb begin
    hw_act = HW_HOLD;
    if (tick_i && run_i) begin
      if (cm_seen_q) begin
        hw_act = HW_SET;
      end else if (zm_seen_q) begin
        hw_act = HW_CLR;
      end
    end
  end

  assign sw_cmd = sw_decode(sw_set_i, sw_clr_i);

  always_comb begin
    state_d = state_q;
    unique case (sw_cmd)
      SW_FORCE1: state_d = 1'b1;
      SW_FORCE0: state_d = 1'b0;
      SW_BOTH:   state_d = state_q;
      default: begin
        unique case (hw_act)
          HW_SET:  state_d = 1'b1;
          HW_CLR:  state_d = 1'b0;
          default: state_d = state_q;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             run_i,
  input  logic             zero_i,
  input  logic             xfer_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             sw_set_i,
  input  logic             sw_clr_i,
  output logic             match_o,
  output logic             state_o
);

  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] cmp_q;
  logic             cnt_eq;

  tcmp_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .xfer_i     (xfer_i),
    .wr_valid_i (wr_valid_i),
    .wr_ready_o (wr_ready_o),
    .wr_data_i  (wr_data_i),
    .shadow_o   (shadow_q),
    .active_o   (cmp_q)
  );

  tcmp_match #(.CNT_W(CNT_W)) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cnt_i    (cnt_i),
    .active_i (cmp_q),
    .eq_o     (cnt_eq),
    .match_o  (match_o)
  );

  tcmp_state u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (run_i),
    .eq_i     (cnt_eq),
    .zero_i   (zero_i),
    .sw_set_i (sw_set_i),
    .sw_clr_i (sw_clr_i),
    .state_o  (state_o)
  );

endmodule

// File: rtl/tcmp_chk.sv
module tcmp_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             run_i,
  input logic             xfer_i,
  input logic             wr_valid_i,
  input logic             wr_ready_o,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             sw_set_i,
  input logic             sw_clr_i,
  input logic             match_o,
  input logic             state_o,
  input logic [CNT_W-1:0] shadow_q,
  input logic [CNT_W-1:0] cmp_q
);

  // R1
  shadow_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o) |=> (shadow_q == $past(wr_data_i)));

  // R1
  shadow_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_i && wr_ready_o) |=> $stable(shadow_q));

  // R2
  cmp_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(cmp_q));

  // R2
  cmp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> (cmp_q == $past(shadow_q)));

  // R3
  no_tick_no_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !match_o);

  // R8
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !sw_set_i && !sw_clr_i) |=> $stable(state_o));

  // R9
  sw_force1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_set_i && !sw_clr_i) |=> state_o);

  // R9
  sw_force0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr_i && !sw_set_i) |=> !state_o);

  // R10
  sw_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_set_i && sw_clr_i) |=> $stable(state_o));

endmodule

bind tmr_cmp_chan tcmp_chk #(.CNT_W(CNT_W)) u_tcmp_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .run_i      (run_i),
  .xfer_i     (xfer_i),
  .wr_valid_i (wr_valid_i),
  .wr_ready_o (wr_ready_o),
  .wr_data_i  (wr_data_i),
  .sw_set_i   (sw_set_i),
  .sw_clr_i   (sw_clr_i),
  .match_o    (match_o),
  .state_o    (state_o),
  .shadow_q   (shadow_q),
  .cmp_q      (cmp_q)
);

// File: tb/tb_tmr_cmp_chan.sv
`timescale 1ns/1ps
module tb_tmr_cmp_chan;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic          run = 1'b0;
  logic          zero = 1'b0;
  logic          xfer = 1'b0;
  logic          wv = 1'b0;
  logic          wr_ready;
  logic [CW-1:0] wd = '0;
  logic          sset = 1'b0;
  logic          sclr = 1'b0;
  logic          match;
  logic          state;

  always #5 clk = ~clk;

  tmr_cmp_chan #(.CNT_W(CW)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .cnt_i      (cnt),
    .run_i      (run),
    .zero_i     (zero),
    .xfer_i     (xfer),
    .wr_valid_i (wv),
    .wr_ready_o (wr_ready),
    .wr_data_i  (wd),
    .sw_set_i   (sset),
    .sw_clr_i   (sclr),
    .match_o    (match),
    .state_o    (state)
  );

  typedef struct {
    bit    m;
    bit    s;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  // Bench model state
  logic [CW-1:0] m_shadow = '0;
  logic [CW-1:0] m_cmp = '0;
  bit            m_state = 1'b0;
  bit            m_cm = 1'b0;
  bit            m_zm = 1'b0;

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Driver: one clock cycle of stimulus, pushes the expected outcome.
  task automatic cyc(input bit tk, input logic [CW-1:0] c, input bit rn, input bit zr,
                     input bit xf, input bit v, input logic [CW-1:0] d,
                     input bit ss, input bit sc, input string tag);
    exp_t e;
    bit   nxt;
    @(negedge clk);
    tick = tk; cnt = c; run = rn; zero = zr; xfer = xf;
    wv = v; wd = d; sset = ss; sclr = sc;
    #1;
    check("R1", wr_ready, !xf, "wr_ready");
    e.m = tk && (c == m_cmp);
    nxt = m_state;
    if (ss && !sc)      nxt = 1'b1;
    else if (sc && !ss) nxt = 1'b0;
    else if (!ss && !sc && tk && rn) begin
      if (m_cm)      nxt = 1'b1;
      else if (m_zm) nxt = 1'b0;
    end
    e.s = nxt;
    e.tag = tag;
    exp_q.push_back(e);
    if (tk) begin
      m_cm = rn && (c == m_cmp);
      m_zm = rn && zr;
    end
    m_state = nxt;
    if (xf) m_cmp = m_shadow;
    if (v && !xf) m_shadow = d;
  endtask

  task automatic idle(input string tag);
    cyc(0, cnt, run, 0, 0, 0, '0, 0, 0, tag);
  endtask

  // Running tick helper
  task automatic rtick(input logic [CW-1:0] c, input bit zr, input string tag);
    cyc(1, c, 1, zr, 0, 0, '0, 0, 0, tag);
  endtask

  // Monitor: pops the expected item after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check(it.tag, match, it.m, "match");
        check(it.tag, state, it.s, "state");
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset values
    check("R11", state, 1'b0, "state");
    check("R11", match, 1'b0, "match");
    check("R11", wr_ready, 1'b1, "wr_ready");
    rst_n = 1'b1;

    // R11: compare register is 0 after reset, so a tick at count 0 matches (R4: stopped timer)
    cyc(1, 16'd0, 0, 0, 0, 0, '0, 0, 0, "R11");
    idle("R4");
    check("R8", state, 1'b0, "state stopped");

    // R1/R2: write 100, transfer with a blocked write of 200, then retry
    cyc(0, 16'd5, 0, 0, 0, 1, 16'd100, 0, 0, "R1");
    cyc(1, 16'd100, 0, 0, 0, 0, '0, 0, 0, "R2");     // shadow only: no match
    cyc(0, 16'd5, 0, 0, 1, 1, 16'd200, 0, 0, "R1");   // ready low
    cyc(0, 16'd5, 0, 0, 0, 1, 16'd200, 0, 0, "R1");   // taken now
    cyc(1, 16'd100, 0, 0, 0, 0, '0, 0, 0, "R2");     // active is 100
    cyc(1, 16'd200, 0, 0, 0, 0, '0, 0, 0, "R2");     // 200 not active yet
    // R3: held counter at compare value, no tick -> no repeat pulse
    cyc(0, 16'd100, 0, 0, 0, 0, '0, 0, 0, "R3");
    cyc(0, 16'd100, 0, 0, 0, 0, '0, 0, 0, "R3");
    cyc(0, 16'd5, 0, 0, 1, 0, '0, 0, 0, "R2");       // active -> 200
    cyc(1, 16'd200, 0, 0, 0, 0, '0, 0, 0, "R2");
    // back to 100
    cyc(0, 16'd5, 0, 0, 0, 1, 16'd100, 0, 0, "R1");
    cyc(0, 16'd5, 0, 0, 1, 0, '0, 0, 0, "R2");

    // R5: running count through the compare value, idle cycles between ticks
    for (int i = 98; i <= 103; i++) begin
      rtick(i[CW-1:0], 0, "R5");
      idle("R5");
    end
    // R7: zero match without compare match clears on next tick
    rtick(16'd0, 1, "R7");
    idle("R7");
    rtick(16'd1, 0, "R7");
    rtick(16'd2, 0, "R7");

    // R8: events while stopped are not applied
    cyc(1, 16'd100, 0, 0, 0, 0, '0, 0, 0, "R8");
    rtick(16'd101, 0, "R8");
    rtick(16'd102, 0, "R8");
    // R8: event seen while running, next tick stopped -> dropped
    rtick(16'd100, 0, "R8");
    cyc(1, 16'd101, 0, 0, 0, 0, '0, 0, 0, "R8");
    rtick(16'd102, 0, "R8");

    // R6: compare value 0, zero and compare match together
    cyc(0, 16'd5, 1, 0, 0, 1, 16'd0, 0, 0, "R6");
    cyc(0, 16'd5, 1, 0, 1, 0, '0, 0, 0, "R6");
    rtick(16'd0, 1, "R6");
    rtick(16'd1, 0, "R6");
    rtick(16'd2, 0, "R6");

    // R9: software clear beats a pending hardware set
    rtick(16'd0, 1, "R9");
    cyc(1, 16'd1, 1, 0, 0, 0, '0, 0, 1, "R9");
    rtick(16'd2, 0, "R9");
    // R9: software set beats a pending hardware clear (compare back to 100)
    cyc(0, 16'd5, 1, 0, 0, 1, 16'd100, 0, 0, "R9");
    cyc(0, 16'd5, 1, 0, 1, 0, '0, 0, 0, "R9");
    rtick(16'd0, 1, "R9");
    cyc(1, 16'd1, 1, 0, 0, 0, '0, 1, 0, "R9");
    // R9: software strobes while stopped
    cyc(0, 16'd1, 0, 0, 0, 0, '0, 0, 1, "R9");
    cyc(0, 16'd1, 0, 0, 0, 0, '0, 1, 0, "R9");

    // R10: both strobes with a pending clear -> unchanged (stays 1)
    rtick(16'd0, 1, "R10");
    cyc(1, 16'd1, 1, 0, 0, 0, '0, 1, 1, "R10");
    // R10: both strobes from 0 with a pending set -> stays 0
    cyc(0, 16'd1, 1, 0, 0, 0, '0, 0, 1, "R10");
    rtick(16'd100, 0, "R10");
    cyc(1, 16'd101, 1, 0, 0, 0, '0, 1, 1, "R10");
    idle("R10");

    // R4: match pulse while the state bit is 1
    cyc(0, 16'd5, 1, 0, 0, 0, '0, 1, 0, "R4");
    rtick(16'd100, 0, "R4");
    idle("R4");

    idle("END");
    idle("END");
    done = 1'b1;
    finish_run();
  end

endmodule